// File: doc/BRIEF.md
# Block Truncation Coding Pixel Decoder

This block turns one compressed record of block truncation coding back into the pixels of a 4x4 block. A record carries a 16-bit selection map and two 8-bit levels. The low level is used for dark pixels and the high level for bright pixels. Each map bit chooses which of the two levels is written to its pixel position. No arithmetic is done on the pixel path.

A record is offered with `in_valid` and is taken on a clock edge where `in_ready` is also high. The 16 rebuilt pixels then leave one per clock on `out_pixel`, qualified by `out_valid`. `out_last` marks the final pixel of the block. The decoder is ready again while it issues that final pixel, so a source that always has a record waiting gets a continuous pixel stream with no idle cycle between blocks.

Top module: `btc_block_decoder`

## Requirements
- R1: After synchronous reset, `out_valid` and `out_last` are low and `in_ready` is high.
- R2: A pixel whose map bit is 0 is output with the value of `in_lvl_lo` captured with its record.
- R3: A pixel whose map bit is 1 is output with the value of `in_lvl_hi` captured with its record.
- R4: Pixels leave in raster order. The k-th valid pixel of a block (k = 0..15) is selected by bit k of `in_bitmap`, where bit 0 is the least significant bit.
- R5: Each accepted record produces exactly 16 `out_valid` cycles, and those cycles are consecutive.
- R6: `out_last` is high only together with `out_valid`, and only on the 16th pixel of a block.
- R7: `in_ready` is high exactly when the decoder is idle or is issuing the 16th pixel of a block.
- R8: A record offered while `in_ready` is low is ignored. It creates no pixels and does not change the block in progress.
- R9: A record accepted in the cycle of a block's 16th pixel has its first pixel in the very next cycle, with no gap in `out_valid`.
- R10: The first pixel of an accepted record appears in the cycle right after the acceptance edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A record is presented |
| in_ready | output | 1 | Decoder can take a record this cycle |
| in_bitmap | input | 16 | Selection map; bit k selects the level for pixel k |
| in_lvl_lo | input | 8 | Level used for map bit 0 |
| in_lvl_hi | input | 8 | Level used for map bit 1 |
| out_valid | output | 1 | `out_pixel` carries a pixel |
| out_pixel | output | 8 | Rebuilt pixel value |
| out_last | output | 1 | 16th pixel of the block |

## Verification
The level checks assume that the record fields are meaningful only on the edge where `in_valid` and `in_ready` are both high. The block does not depend on the source holding the fields stable at any other time. The driver therefore changes the fields only away from the clock edge. It keeps `in_valid` raised until it sees `in_ready`, which makes acceptance fall on the 16th-pixel cycle during back-to-back runs. One scenario deliberately presents decoy records while `in_ready` is low and drops them before readiness returns. This shows at the pixel output that such records are never taken.

// File: rtl/btc_dec_pkg.sv
package btc_dec_pkg;

    parameter int PIX_W  = 8;
    parameter int BLK_W  = 4;
    parameter int BLK_H  = 4;

    localparam int NPIX     = BLK_W * BLK_H;
    localparam int IDX_W    = $clog2(NPIX);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NPIX - 1);

    typedef logic [NPIX-1:0]  sel_map_t;
    typedef logic [PIX_W-1:0] pix_t;
    typedef logic [IDX_W-1:0] idx_t;

    typedef struct packed {
        sel_map_t map;
        pix_t     lo;
        pix_t     hi;
    } btc_rec_t;

    typedef enum logic {
        SCAN_IDLE = 1'b0,
        SCAN_RUN  = 1'b1
    } scan_state_e;

    function automatic pix_t pick_level(input logic bit_sel, input pix_t lo, input pix_t hi);
        return bit_sel ? hi : lo;
    endfunction

endpackage

// File: rtl/btc_rec_reg.sv
module btc_rec_reg
    import btc_dec_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  btc_rec_t rec_in,
    output btc_rec_t rec_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rec_q <= '0;
        end else if (load) begin
            rec_q <= rec_in;
        end
    end

endmodule

// File: rtl/btc_scan_ctrl.sv
module btc_scan_ctrl
    import btc_dec_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic take,
    output logic can_take,
    output logic active,
    output logic at_last,
    output idx_t pos
);

    scan_state_e state_q;
    idx_t        pos_q;

    assign active   = (state_q == SCAN_RUN);
    assign at_last  = active && (pos_q == LAST_IDX);
    assign can_take = !active || at_last;
    assign pos      = pos_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SCAN_IDLE;
            pos_q   <= '0;
        end else if (take) begin
            state_q <= SCAN_RUN;
            pos_q   <= '0;
        end else if (active) begin
            if (pos_q == LAST_IDX) begin
                state_q <= SCAN_IDLE;
                pos_q   <= '0;
            end else begin
                pos_q <= pos_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/btc_level_mux.sv
module btc_level_mux
    import btc_dec_pkg::*;
(
    input  btc_rec_t rec,
    input  idx_t     pos,
    output pix_t     pix
);

    logic [NPIX-1:0] hit;
    pix_t            cand [NPIX];

    for (genvar k = 0; k < NPIX; k++) begin : g_slot
        assign hit[k]  = (pos == idx_t'(k));
        assign cand[k] = pick_level(rec.map[k], rec.lo, rec.hi);
    end

    always_comb begin
        pix = '0;
        for (int k = 0; k < NPIX; k++) begin
            if (hit[k]) pix = cand[k];
        end
    end

endmodule

// File: rtl/btc_block_decoder.sv
module btc_block_decoder
    import btc_dec_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [NPIX-1:0]  in_bitmap,
    input  logic [PIX_W-1:0] in_lvl_lo,
    input  logic [PIX_W-1:0] in_lvl_hi,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_pixel,
    output logic             out_last
);

    btc_rec_t rec_in;
    btc_rec_t rec_q;
    logic     take;
    logic     active;
    logic     at_last;
    idx_t     pos;
    pix_t     sel_pix;

    assign rec_in = '{map: in_bitmap, lo: in_lvl_lo, hi: in_lvl_hi};
    assign take   = in_valid && in_ready;

    btc_scan_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .take     (take),
        .can_take (in_ready),
        .active   (active),
        .at_last  (at_last),
        .pos      (pos)
    );

    btc_rec_reg u_rec (
        .clk    (clk),
        .rst    (rst),
        .load   (take),
        .rec_in (rec_in),
        .rec_q  (rec_q)
    );

    btc_level_mux u_mux (
        .rec (rec_q),
        .pos (pos),
        .pix (sel_pix)
    );

    assign out_valid = active;
    assign out_last  = at_last;
    assign out_pixel = active ? sel_pix : '0;

endmodule

// File: rtl/btc_block_decoder_chk.sv
module btc_block_decoder_chk
    import btc_dec_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic [NPIX-1:0]  in_bitmap,
    input logic [PIX_W-1:0] in_lvl_lo,
    input logic [PIX_W-1:0] in_lvl_hi,
    input logic             out_valid,
    input logic [PIX_W-1:0] out_pixel,
    input logic             out_last
);

    logic acc;
    idx_t seen_q;

    assign acc = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst || acc) seen_q <= '0;
        else if (out_valid) seen_q <= seen_q + 1'b1;
    end

    AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (rst) out_last |-> out_valid); // R6
    AST_LAST_AT_16TH: assert property (@(posedge clk) disable iff (rst) out_last |-> seen_q == LAST_IDX); // R6
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst) (out_valid && !out_last) |-> !in_ready); // R7
    AST_IDLE_READY: assert property (@(posedge clk) disable iff (rst) !out_valid |-> in_ready); // R7
    AST_FIRST_NEXT: assert property (@(posedge clk) disable iff (rst) acc |=> out_valid); // R10
    AST_NO_HOLE: assert property (@(posedge clk) disable iff (rst) (out_valid && !out_last) |=> out_valid); // R5
    AST_STOP_AFTER: assert property (@(posedge clk) disable iff (rst) (out_last && !acc) |=> !out_valid); // R5
    AST_LO_FIRST: assert property (@(posedge clk) disable iff (rst) (acc && !in_bitmap[0]) |=> out_pixel == $past(in_lvl_lo)); // R2
    AST_HI_FIRST: assert property (@(posedge clk) disable iff (rst) (acc && in_bitmap[0]) |=> out_pixel == $past(in_lvl_hi)); // R3

endmodule

bind btc_block_decoder btc_block_decoder_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_bitmap (in_bitmap),
    .in_lvl_lo (in_lvl_lo),
    .in_lvl_hi (in_lvl_hi),
    .out_valid (out_valid),
    .out_pixel (out_pixel),
    .out_last  (out_last)
);

// File: tb/btc_block_decoder_tb.sv
module btc_block_decoder_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_bitmap = '0;
    logic [7:0]  in_lvl_lo = '0;
    logic [7:0]  in_lvl_hi = '0;
    logic        out_valid;
    logic [7:0]  out_pixel;
    logic        out_last;

    int total = 0;
    int bad   = 0;
    int run_len = 0;
    int max_run = 0;
    bit finished = 0;

    typedef struct {
        logic [7:0] pix;
        logic       last;
        logic       bit_sel;
        int         idx;
    } exp_t;

    exp_t q[$];

    always #10 clk = ~clk;

    btc_block_decoder u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_bitmap(in_bitmap), .in_lvl_lo(in_lvl_lo), .in_lvl_hi(in_lvl_hi),
        .out_valid(out_valid), .out_pixel(out_pixel), .out_last(out_last)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: scoreboard pop and ready rule
    always @(negedge clk) begin
        if (!rst) begin
            check(in_ready == (!out_valid || out_last), "R7 in_ready", in_ready, !out_valid || out_last);
            if (!out_valid) check(!out_last, "R6 last without valid", out_last, 0);
            if (out_valid) begin
                run_len++;
                if (run_len > max_run) max_run = run_len;
                if (q.size() == 0) begin
                    check(0, "R8 unexpected pixel", out_pixel, -1);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    if (e.bit_sel)
                        check(out_pixel == e.pix, $sformatf("R3 R4 pixel %0d", e.idx), out_pixel, e.pix);
                    else
                        check(out_pixel == e.pix, $sformatf("R2 R4 pixel %0d", e.idx), out_pixel, e.pix);
                    check(out_last == e.last, $sformatf("R6 last at pixel %0d", e.idx), out_last, e.last);
                end
            end else begin
                run_len = 0;
            end
        end
    end

    task automatic send(input logic [15:0] m, input logic [7:0] lo, input logic [7:0] hi);
        @(negedge clk);
        in_valid  = 1'b1;
        in_bitmap = m;
        in_lvl_lo = lo;
        in_lvl_hi = hi;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        for (int k = 0; k < 16; k++) begin
            exp_t e;
            e.bit_sel = m[k];
            e.pix     = m[k] ? hi : lo;
            e.last    = (k == 15);
            e.idx     = k;
            q.push_back(e);
        end
        #1;
        in_valid = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b1, "R10 first pixel next cycle", out_valid, 1);
    endtask

    task automatic drain();
        while (q.size() != 0) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R5 stops after 16", out_valid, 0);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid reset", out_valid, 0);
        check(out_last == 1'b0, "R1 out_last reset", out_last, 0);
        check(in_ready == 1'b1, "R1 in_ready reset", in_ready, 1);
        rst = 1'b0;

        // single blocks, varied patterns (R2 R3 R4)
        send(16'h0000, 8'd17, 8'd200); drain();
        send(16'hFFFF, 8'd3, 8'd250);  drain();
        send(16'h0001, 8'h10, 8'hE0);  drain();
        send(16'h8000, 8'h22, 8'hCC);  drain();
        send(16'hA5C3, 8'd0, 8'd255);  drain();

        // back-to-back blocks (R9)
        max_run = 0;
        send(16'h1234, 8'd40, 8'd90);
        send(16'hF00F, 8'd5, 8'd6);
        send(16'h5AA5, 8'd128, 8'd127);
        drain();
        check(max_run >= 48, "R9 no bubble", max_run, 48);

        // decoys while not ready are ignored (R8)
        send(16'h0F0F, 8'd11, 8'd99);
        for (int k = 0; k < 10; k++) begin
            in_valid  = 1'b1;
            in_bitmap = 16'hFFFF ^ 16'(k);
            in_lvl_lo = 8'd77;
            in_lvl_hi = 8'd66;
            @(negedge clk);
        end
        in_valid = 1'b0;
        drain();
        check(q.size() == 0, "R8 decoys dropped", q.size(), 0);

        repeat (4) @(negedge clk);
        finished = 1;
        finish_run();
    end

endmodule